// File: doc/BRIEF.md
# I2C Reset-Call Detector

This block listens on an I2C bus from the slave side and reacts to only one transaction, a reserved reset call. After a START, the master sends the reserved address byte 06h, which is the 7-bit address 0000011 with the write bit cleared. It then sends two key bytes, A5h followed by 5Ah, and closes with a STOP. The block acknowledges each byte of this sequence only while the sequence still matches. It stays silent on any other byte. When the STOP arrives after the full match, it raises a one-cycle synchronous clear that returns a neighbouring register bank to all zeros.

SCL and SDA are sampled with the system clock through a synchronizer. START and STOP are found from the sampled lines. The acknowledge is given through an open-drain pull-down output, which the surrounding pad logic turns into a low on SDA. An active-low supply-good input holds the whole block in its zero state until power is stable. The block does not take part in ordinary register addressing, does not stretch the clock and does not filter the bus lines.

Top module: `i2c_reset_call_detector`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high, both seen on the synchronized lines. Bytes that are not preceded by a START are never acknowledged.
- R2: The first byte after a START is acknowledged only when it equals 06h. The byte 07h (read bit set) and every other value get no acknowledge, and the rest of that transfer is then ignored.
- R3: The byte after an acknowledged address is acknowledged only when it equals A5h. Any other value ends the sequence and no later byte of that transfer is acknowledged.
- R4: The byte after an acknowledged A5h is acknowledged only when it equals 5Ah. Any other value ends the sequence.
- R5: A STOP that directly follows the three matching bytes makes `clearPulse` high for exactly one system-clock cycle. No other event raises it.
- R6: A further byte after 5Ah is not acknowledged, and it cancels the pending clear. A repeated START after 5Ah also cancels the pending clear, and it begins a new sequence that is checked from its address byte.
- R7: A START or STOP that arrives after two or more SCL rising edges of the current byte returns the block to idle with no clear. After such a START, the next byte is not treated as an address.
- R8: `sdaPullDown` rises on the SCL falling edge that ends the eighth bit of an accepted byte. It stays high through the ninth SCL high phase and drops on the next SCL falling edge. At all other times it is low.
- R9: While `supplyOk` is low, `sdaPullDown` and `clearPulse` are low and any sequence in progress is lost. After release, the block is idle and it accepts a complete new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| supplyOk | input | 1 | Active-low reset; low holds the block in its zero state |
| sclIn | input | 1 | Bus clock line as received |
| sdaIn | input | 1 | Bus data line as received (wired level) |
| sdaPullDown | output | 1 | High drives SDA low for an acknowledge |
| clearPulse | output | 1 | One-cycle synchronous clear for the register bank |

## Verification
The full valid sequence is run, and then variants that differ from it in one place each. These are the read bit in the address, a wrong first key, a wrong second key, an extra trailing byte, and a repeated START before the STOP. Each variant shows whether the decision is made per byte and whether the clear is tied to the STOP. A STOP and a START are also placed partway through a byte, which tells a framing error apart from a legal repeated START at a byte boundary. The bytes sent after the mid-byte START check that no START is assumed. Finally, the supply-good input is dropped between the last key byte and the STOP, to show that a sequence cannot survive a reset. The acknowledge line is sampled in the low phase before the ninth clock, in the ninth high phase and after the ninth falling edge, so that its timing is checked as well as its value.

// File: rtl/swrst_pkg.sv
package swrst_pkg;

  // Bus events reported by the datapath to the control.
  typedef struct packed {
    logic startSeen;
    logic stopSeen;
    logic byteDone;
    logic midByte;
  } busEvt_t;

  // Strobes from control to the datapath.
  typedef struct packed {
    logic ackArm;
  } ctrlCmd_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_KEY0,
    ST_KEY1,
    ST_ARMED,
    ST_DEAF
  } seqState_t;

endpackage

// File: rtl/swrst_datapath.sv
module swrst_datapath
  import swrst_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  ctrlCmd_t          cmd,
  output busEvt_t           evt,
  output logic [BYTE_W-1:0] byteVal,
  output logic              sdaPullDown
);

  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_DONE  = CNT_W'(BYTE_W + 1);
  localparam logic [CNT_W-1:0] MID_EDGES = CNT_W'(2);

  // Two lines are synchronized: index 1 is SCL, index 0 is SDA.
  logic [1:0] lineRaw;
  logic [1:0] lineSync;
  assign lineRaw = {sclIn, sdaIn};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] stg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg <= '1;
      else       stg <= {stg[SYNC_STAGES-2:0], lineRaw[g]};
    end
    assign lineSync[g] = stg[SYNC_STAGES-1];
  end

  logic sclS, sdaS, sclP, sdaP;
  assign sclS = lineSync[1];
  assign sdaS = lineSync[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclP <= sclS;
      sdaP <= sdaS;
    end
  end

  logic sclRise, sclFall, startNow, stopNow;
  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;
  assign startNow = sclS & sclP & sdaP & ~sdaS;
  assign stopNow  = sclS & sclP & ~sdaP & sdaS;

  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-2:0] shiftQ;
  logic              ackPend;
  logic              ackOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      shiftQ  <= '0;
      ackPend <= 1'b0;
      ackOn   <= 1'b0;
    end else if (startNow || stopNow) begin
      bitCnt  <= '0;
      ackPend <= 1'b0;
      ackOn   <= 1'b0;
    end else begin
      if (cmd.ackArm) ackPend <= 1'b1;
      if (sclRise) begin
        if (bitCnt < ACK_SLOT)  shiftQ <= {shiftQ[BYTE_W-3:0], sdaS};
        if (bitCnt <= ACK_SLOT) bitCnt <= bitCnt + 1'b1;
      end else if (sclFall) begin
        if (bitCnt == ACK_SLOT) begin
          ackOn   <= ackPend;
          ackPend <= 1'b0;
        end else if (bitCnt == ACK_DONE) begin
          ackOn  <= 1'b0;
          bitCnt <= '0;
        end
      end
    end
  end

  always_comb begin
    evt.startSeen = startNow;
    evt.stopSeen  = stopNow;
    evt.byteDone  = sclRise && (bitCnt == LAST_DATA);
    evt.midByte   = (bitCnt >= MID_EDGES);
  end

  assign byteVal     = {shiftQ, sdaS};
  assign sdaPullDown = ackOn;

  // The pull-down may only start while SCL is low.
  assert_ack_rises_scl_low_R8 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackOn) |-> !sclS);

  // The pull-down ends with SCL low, or because a framing event was seen.
  assert_ack_falls_quiet_R8 : assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackOn) |-> (!sclS || $past(startNow || stopNow)));

  // A START or STOP always leaves SDA released.
  assert_release_on_frame_R7 : assert property (@(posedge clk) disable iff (!rstN)
    (startNow || stopNow) |=> !ackOn);

endmodule

// File: rtl/swrst_ctrl.sv
module swrst_ctrl
  import swrst_pkg::*;
#(
  parameter int                BYTE_W    = 8,
  parameter logic [BYTE_W-1:0] ADDR_BYTE = 8'h06,
  parameter logic [BYTE_W-1:0] KEY0      = 8'hA5,
  parameter logic [BYTE_W-1:0] KEY1      = 8'h5A
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEvt_t           evt,
  input  logic [BYTE_W-1:0] byteVal,
  output ctrlCmd_t          cmd,
  output logic              clearPulse
);

  seqState_t state, stateNxt;
  logic      armNow, fireNow;

  always_comb begin
    stateNxt = state;
    armNow   = 1'b0;
    fireNow  = 1'b0;
    if (evt.startSeen) begin
      stateNxt = evt.midByte ? ST_IDLE : ST_ADDR;
    end else if (evt.stopSeen) begin
      fireNow  = (state == ST_ARMED) && !evt.midByte;
      stateNxt = ST_IDLE;
    end else if (evt.byteDone) begin
      case (state)
        ST_ADDR: begin
          armNow   = (byteVal == ADDR_BYTE);
          stateNxt = armNow ? ST_KEY0 : ST_DEAF;
        end
        ST_KEY0: begin
          armNow   = (byteVal == KEY0);
          stateNxt = armNow ? ST_KEY1 : ST_DEAF;
        end
        ST_KEY1: begin
          armNow   = (byteVal == KEY1);
          stateNxt = armNow ? ST_ARMED : ST_DEAF;
        end
        ST_ARMED: stateNxt = ST_DEAF;
        default:  stateNxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      clearPulse <= 1'b0;
    end else begin
      state      <= stateNxt;
      clearPulse <= fireNow;
    end
  end

  assign cmd.ackArm = armNow;

  assert_single_cycle_pulse_R5 : assert property (@(posedge clk) disable iff (!rstN)
    clearPulse |=> !clearPulse);

  assert_pulse_follows_stop_R5 : assert property (@(posedge clk) disable iff (!rstN)
    clearPulse |-> $past(evt.stopSeen));

  assert_arm_advances_R2 : assert property (@(posedge clk) disable iff (!rstN)
    cmd.ackArm |=> (state == ST_KEY0 || state == ST_KEY1 || state == ST_ARMED));

  assert_start_no_clear_R6 : assert property (@(posedge clk) disable iff (!rstN)
    evt.startSeen |=> !clearPulse);

endmodule

// File: rtl/i2c_reset_call_detector.sv
module i2c_reset_call_detector
  import swrst_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter int                BYTE_W      = 8,
  parameter logic [BYTE_W-1:0] ADDR_BYTE   = 8'h06,
  parameter logic [BYTE_W-1:0] KEY0        = 8'hA5,
  parameter logic [BYTE_W-1:0] KEY1        = 8'h5A
) (
  input  logic clk,
  input  logic supplyOk,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaPullDown,
  output logic clearPulse
);

  busEvt_t           evt;
  ctrlCmd_t          cmd;
  logic [BYTE_W-1:0] byteVal;

  swrst_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .BYTE_W     (BYTE_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (supplyOk),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .cmd        (cmd),
    .evt        (evt),
    .byteVal    (byteVal),
    .sdaPullDown(sdaPullDown)
  );

  swrst_ctrl #(
    .BYTE_W   (BYTE_W),
    .ADDR_BYTE(ADDR_BYTE),
    .KEY0     (KEY0),
    .KEY1     (KEY1)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (supplyOk),
    .evt       (evt),
    .byteVal   (byteVal),
    .cmd       (cmd),
    .clearPulse(clearPulse)
  );

endmodule

// File: tb/i2c_reset_call_detector_tb.sv
module i2c_reset_call_detector_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 8;

  logic clk = 1'b0;
  logic supplyOk = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaLine;
  logic sdaPullDown;
  logic clearPulse;

  int nChk = 0;
  int nFail = 0;
  int pulseCnt = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign sdaLine = sdaM & ~sdaPullDown;

  i2c_reset_call_detector dut_i (
    .clk        (clk),
    .supplyOk   (supplyOk),
    .sclIn      (sclM),
    .sdaIn      (sdaLine),
    .sdaPullDown(sdaPullDown),
    .clearPulse (clearPulse)
  );

  always @(posedge clk) if (clearPulse === 1'b1) pulseCnt <= pulseCnt + 1;

  task automatic q();
    repeat (QTR) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b0; q();
    sclM = 1'b0; q();
  endtask

  task automatic busRestart();
    sdaM = 1'b1; q();
    sclM = 1'b1; q();
    sdaM = 1'b0; q();
    sclM = 1'b0; q();
  endtask

  task automatic busStop();
    sdaM = 1'b0; q();
    sclM = 1'b1; q();
    sdaM = 1'b1; q();
  endtask

  task automatic clockBit(input logic b);
    sdaM = b;    q();
    sclM = 1'b1; q();
    sclM = 1'b0; q();
  endtask

  // Eight data bits, then the ninth clock with the master releasing SDA.
  task automatic sendByte(input logic [7:0] val, input logic expAck, input string req);
    for (int i = 7; i >= 0; i--) clockBit(val[i]);
    sdaM = 1'b1; q();
    chk(req, $sformatf("R8 ack before 9th clock, byte %02h", val), int'(sdaPullDown), int'(expAck));
    sclM = 1'b1; q();
    chk(req, $sformatf("ack in 9th high, byte %02h", val), int'(sdaPullDown), int'(expAck));
    sclM = 1'b0; q();
    chk("R8", $sformatf("release after 9th clock, byte %02h", val), int'(sdaPullDown), 0);
  endtask

  task automatic expectPulses(input int base, input int exp, input string req);
    q();
    chk(req, "clear pulse count", pulseCnt - base, exp);
  endtask

  // R5: complete valid call
  task automatic tValid();
    int base = pulseCnt;
    busStart();
    sendByte(8'h06, 1'b1, "R2");
    sendByte(8'hA5, 1'b1, "R3");
    sendByte(8'h5A, 1'b1, "R4");
    busStop();
    expectPulses(base, 1, "R5");
  endtask

  // R2: read bit set
  task automatic tReadBit();
    int base = pulseCnt;
    busStart();
    sendByte(8'h07, 1'b0, "R2");
    sendByte(8'hA5, 1'b0, "R2");
    sendByte(8'h5A, 1'b0, "R2");
    busStop();
    expectPulses(base, 0, "R2");
  endtask

  // R3: wrong first key
  task automatic tBadKey0();
    int base = pulseCnt;
    busStart();
    sendByte(8'h06, 1'b1, "R2");
    sendByte(8'hA4, 1'b0, "R3");
    sendByte(8'h5A, 1'b0, "R3");
    busStop();
    expectPulses(base, 0, "R3");
  endtask

  // R4: wrong second key
  task automatic tBadKey1();
    int base = pulseCnt;
    busStart();
    sendByte(8'h06, 1'b1, "R2");
    sendByte(8'hA5, 1'b1, "R3");
    sendByte(8'h5B, 1'b0, "R4");
    busStop();
    expectPulses(base, 0, "R4");
  endtask

  // R6: trailing byte cancels
  task automatic tExtraByte();
    int base = pulseCnt;
    busStart();
    sendByte(8'h06, 1'b1, "R2");
    sendByte(8'hA5, 1'b1, "R3");
    sendByte(8'h5A, 1'b1, "R4");
    sendByte(8'h00, 1'b0, "R6");
    busStop();
    expectPulses(base, 0, "R6");
  endtask

  // R6: repeated START cancels, then a new sequence is checked afresh
  task automatic tRestart();
    int base = pulseCnt;
    busStart();
    sendByte(8'h06, 1'b1, "R2");
    sendByte(8'hA5, 1'b1, "R3");
    sendByte(8'h5A, 1'b1, "R4");
    busRestart();
    chk("R6", "no clear on repeated START", pulseCnt - base, 0);
    sendByte(8'h06, 1'b1, "R6");
    sendByte(8'hA5, 1'b1, "R6");
    sendByte(8'h5A, 1'b1, "R6");
    busStop();
    expectPulses(base, 1, "R6");
  endtask

  // R7: STOP in the middle of a key byte
  task automatic tMidStop();
    int base = pulseCnt;
    busStart();
    sendByte(8'h06, 1'b1, "R2");
    clockBit(1'b1); clockBit(1'b0); clockBit(1'b1); clockBit(1'b0);
    busStop();
    expectPulses(base, 0, "R7");
  endtask

  // R7 and R1: START in the middle of a byte; following bytes are not an address
  task automatic tMidStart();
    int base = pulseCnt;
    busStart();
    sendByte(8'h06, 1'b1, "R2");
    clockBit(1'b1); clockBit(1'b0); clockBit(1'b1);
    sdaM = 1'b1; q();
    sclM = 1'b1; q();
    sdaM = 1'b0; q();
    sclM = 1'b0; q();
    sendByte(8'h06, 1'b0, "R7");
    sendByte(8'hA5, 1'b0, "R1");
    sendByte(8'h5A, 1'b0, "R1");
    busStop();
    expectPulses(base, 0, "R7");
  endtask

  // R9: supply-good drop before the STOP
  task automatic tSupplyDrop();
    int base = pulseCnt;
    busStart();
    sendByte(8'h06, 1'b1, "R2");
    sendByte(8'hA5, 1'b1, "R3");
    clockBit(1'b0); clockBit(1'b1); clockBit(1'b0); clockBit(1'b1);
    clockBit(1'b1); clockBit(1'b0); clockBit(1'b1); clockBit(1'b0);
    supplyOk = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "pull-down held low in reset", int'(sdaPullDown), 0);
    chk("R9", "clear low in reset", int'(clearPulse), 0);
    supplyOk = 1'b1;
    sdaM = 1'b1; q();
    sclM = 1'b1; q();
    sclM = 1'b0; q();
    busStop();
    expectPulses(base, 0, "R9");
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1;
    chk("R9", "reset pull-down", int'(sdaPullDown), 0);
    chk("R9", "reset clear", int'(clearPulse), 0);
    supplyOk = 1'b1;
    q();
    tValid();
    tReadBit();
    tBadKey0();
    tBadKey1();
    tExtraByte();
    tRestart();
    tMidStop();
    tValid();
    tMidStart();
    tSupplyDrop();
    tValid();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule